// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one byte per handshake into an asynchronous serial frame on a single output line. A frame is a start bit, eight data bits, an optional ninth bit and one or two stop bits. The start and stop levels can each be chosen high or low. The line rests at the opposite of the start level. The ninth bit carries either a literal control value or a computed parity bit. The data bits can go out least-significant first or most-significant first.

Timing comes from a single-cycle bit tick supplied from outside, so the block holds no rate divider. After a byte is accepted, the frame begins on the next tick and each bit lasts one tick period. The whole configuration is captured when the byte is accepted. Optional flow control holds off new frames while an active-low clear-to-send input is deasserted. A flush pulse abandons the frame in progress at once.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `busy` is 0, `tx_ready` is 1 when flow control is off, and `txd` rests at the inverse of `cfg_start_lvl`.
- R2: While idle, `txd` follows the inverse of the live `cfg_start_lvl` input.
- R3: After a byte is accepted (`tx_valid` and `tx_ready` both high at a clock edge), the frame starts at the next clock edge with `bit_tick` high. The start bit at `cfg_start_lvl` is visible after that edge, and each following tick edge presents the next bit.
- R4: With `cfg_msb_first` 0, the data bits are sent with bit 0 first. With `cfg_msb_first` 1, they are sent with bit 7 first.
- R5: With `cfg_nine_bit` 1 and `cfg_parity_en` 0, one extra bit equal to `cfg_d9` follows the data bits. With `cfg_nine_bit` 0, no extra bit is sent.
- R6: With `cfg_nine_bit` and `cfg_parity_en` both 1, the ninth bit is parity over the eight data bits. `cfg_d9` 0 makes the total count of ones, ninth bit included, even. `cfg_d9` 1 makes that total odd.
- R7: Stop bits are driven at `cfg_stop_lvl`. There is one stop bit when `cfg_two_stop` is 0 and two when it is 1. The line returns to rest at the tick edge after the last stop bit.
- R8: With `cfg_flow_en` 1, `tx_ready` stays low and no frame starts while the synchronized `cts_n` is high. With `cfg_flow_en` 0, `cts_n` has no effect on `tx_ready` or on the frame.
- R9: A high `flush` at a clock edge ends any frame in progress. After that edge, `busy` is 0 and `txd` is at rest. `tx_ready` is low during the flush cycle.
- R10: The configuration inputs are captured when the byte is accepted. Changing them mid-frame does not alter that frame.
- R11: `tx_ready` is high only while idle. `busy` is high from the accept edge until the tick edge that ends the last stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte available |
| tx_ready | output | 1 | Transmitter can accept a byte this cycle |
| cfg_start_lvl | input | 1 | Start-bit level; rest level is its inverse |
| cfg_stop_lvl | input | 1 | Stop-bit level |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_nine_bit | input | 1 | Append a ninth bit |
| cfg_parity_en | input | 1 | Ninth bit is parity instead of a literal |
| cfg_d9 | input | 1 | Literal ninth bit, or parity sense (0 even, 1 odd) |
| cfg_msb_first | input | 1 | Data order: 0 bit 0 first, 1 bit 7 first |
| cfg_flow_en | input | 1 | Honour clear-to-send |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| bit_tick | input | 1 | Single-cycle bit-rate strobe |
| flush | input | 1 | Abort the current frame |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame pending or in progress |

## Verification
The assertions assume that `bit_tick` is a single-cycle strobe with at least one idle cycle between pulses. They also assume `flush` is synchronous to `clk`, and that reset is held for at least two clock edges. The bench produces the tick from a free-running divide-by-four counter. It drives all inputs at the falling edge, pulses `flush` for exactly one cycle, and changes `cts_n` only while no byte is offered. Random configurations and data come from a seeded generator. Further random values are written to the configuration inputs partway through frames to exercise the capture rule.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic start_lvl;
    logic stop_lvl;
    logic two_stop;
    logic nine_bit;
    logic parity_en;
    logic d9;
    logic msb_first;
  } tx_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2
  } tx_state_t;
endpackage

// File: rtl/uart_tx_rst_sync.sv
module uart_tx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/uart_tx_cts_sync.sv
module uart_tx_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n_async,
  output logic cts_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[STAGES-2:0], cts_n_async};
  end

  assign cts_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data,
  input  tx_cfg_t            cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   frame_len
);
  logic [DATA_W-1:0] data_rev;
  logic [DATA_W-1:0] data_ord;
  logic              ninth;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign data_rev[i] = data[DATA_W-1-i];
  end

  always_comb begin
    data_ord = cfg.msb_first ? data_rev : data;
    ninth    = cfg.d9 ^ (cfg.parity_en & (^data));
    frame    = {FRAME_W{cfg.stop_lvl}};
    frame[0] = cfg.start_lvl;
    frame[DATA_W:1] = data_ord;
    if (cfg.nine_bit) frame[DATA_W+1] = ninth;
    frame_len = CNT_W'(DATA_W + 2) + CNT_W'(cfg.nine_bit) + CNT_W'(cfg.two_stop);
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic               flush,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [CNT_W-1:0]   len_in,
  input  logic               start_live,
  output logic               idle,
  output logic               busy,
  output logic               txd
);
  tx_state_t          state_q, state_d;
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               bit_q, bit_d;
  logic               lat_start_q, lat_start_d;

  always_comb begin
    state_d     = state_q;
    sr_d        = sr_q;
    cnt_d       = cnt_q;
    bit_d       = bit_q;
    lat_start_d = lat_start_q;
    if (flush) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (load) begin
          sr_d        = frame_in;
          cnt_d       = len_in;
          lat_start_d = start_live;
          state_d     = ST_WAIT;
        end
        ST_WAIT: if (bit_tick) begin
          bit_d   = sr_q[0];
          sr_d    = {1'b0, sr_q[FRAME_W-1:1]};
          cnt_d   = cnt_q - 1'b1;
          state_d = ST_SEND;
        end
        ST_SEND: if (bit_tick) begin
          if (cnt_q == '0) begin
            state_d = ST_IDLE;
          end else begin
            bit_d = sr_q[0];
            sr_d  = {1'b0, sr_q[FRAME_W-1:1]};
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      sr_q        <= '0;
      cnt_q       <= '0;
      bit_q       <= 1'b0;
      lat_start_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      sr_q        <= sr_d;
      cnt_q       <= cnt_d;
      bit_q       <= bit_d;
      lat_start_q <= lat_start_d;
    end
  end

  assign idle = (state_q == ST_IDLE);
  assign busy = !idle;
  assign txd  = (state_q == ST_SEND) ? bit_q :
                (state_q == ST_IDLE) ? ~start_live : ~lat_start_q;

  // R9: a flush leaves the core idle on the following cycle
  p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state_q == ST_IDLE));

  // R3: the first tick after acceptance puts the captured start level on the line
  p_start_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && bit_tick && !flush) |=> (txd == lat_start_q));

  // R11: busy cannot drop except by flush or the tick that ends the last bit
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !flush && !(state_q == ST_SEND && bit_tick && cnt_q == '0)) |=> busy);

  // R7: the bit counter never exceeds the longest frame
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              cfg_start_lvl,
  input  logic              cfg_stop_lvl,
  input  logic              cfg_two_stop,
  input  logic              cfg_nine_bit,
  input  logic              cfg_parity_en,
  input  logic              cfg_d9,
  input  logic              cfg_msb_first,
  input  logic              cfg_flow_en,
  input  logic              cts_n,
  input  logic              bit_tick,
  input  logic              flush,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               srst_n;
  logic               cts_n_sync;
  logic               core_idle;
  logic               load;
  tx_cfg_t            cfg;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   frame_len;

  assign cfg = '{start_lvl: cfg_start_lvl, stop_lvl: cfg_stop_lvl,
                 two_stop: cfg_two_stop, nine_bit: cfg_nine_bit,
                 parity_en: cfg_parity_en, d9: cfg_d9,
                 msb_first: cfg_msb_first};

  uart_tx_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  uart_tx_cts_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(srst_n), .cts_n_async(cts_n), .cts_n_sync(cts_n_sync));

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data(tx_data), .cfg(cfg), .frame(frame), .frame_len(frame_len));

  assign tx_ready = core_idle & ~flush & (~cfg_flow_en | ~cts_n_sync);
  assign load     = tx_valid & tx_ready;

  uart_tx_core #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(srst_n), .bit_tick(bit_tick), .flush(flush),
    .load(load), .frame_in(frame), .len_in(frame_len),
    .start_live(cfg_start_lvl), .idle(core_idle), .busy(busy), .txd(txd));

  // R11: the handshake is only offered while no frame is pending
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!srst_n)
    tx_ready |-> !busy);

  // R8: with flow control on, no byte is taken while the synchronized CTS is high
  p_flow_block_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (load && cfg_flow_en) |-> !cts_n_sync);

  // R11: an accepted byte makes the block busy on the next cycle
  p_accept_busy_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (load && !flush) |=> busy);
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic       cfg_start_lvl, cfg_stop_lvl, cfg_two_stop, cfg_nine_bit;
  logic       cfg_parity_en, cfg_d9, cfg_msb_first, cfg_flow_en;
  logic       cts_n;
  logic       bit_tick;
  logic       flush;
  logic       txd;
  logic       busy;

  int checks = 0;
  int errors = 0;
  logic [1:0] tdiv = 2'd0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tdiv     <= tdiv + 2'd1;
    bit_tick <= (tdiv == 2'd3);
  end

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .cfg_start_lvl(cfg_start_lvl),
    .cfg_stop_lvl(cfg_stop_lvl), .cfg_two_stop(cfg_two_stop),
    .cfg_nine_bit(cfg_nine_bit), .cfg_parity_en(cfg_parity_en),
    .cfg_d9(cfg_d9), .cfg_msb_first(cfg_msb_first),
    .cfg_flow_en(cfg_flow_en), .cts_n(cts_n), .bit_tick(bit_tick),
    .flush(flush), .txd(txd), .busy(busy));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // c bit map: 0 start, 1 stop, 2 two_stop, 3 nine_bit, 4 parity_en, 5 d9, 6 msb_first
  task automatic set_cfg(input logic [6:0] c);
    cfg_start_lvl = c[0]; cfg_stop_lvl  = c[1]; cfg_two_stop  = c[2];
    cfg_nine_bit  = c[3]; cfg_parity_en = c[4]; cfg_d9        = c[5];
    cfg_msb_first = c[6];
  endtask

  function automatic logic [11:0] expect_bits(input logic [7:0] d, input logic [6:0] c,
                                              output int n);
    logic [11:0] v = '0;
    int k = 0;
    v[k] = c[0]; k++;
    for (int i = 0; i < 8; i++) begin
      v[k] = c[6] ? d[7-i] : d[i]; k++;
    end
    if (c[3]) begin
      if (c[4]) v[k] = c[5] ? ~(^d) : (^d);
      else      v[k] = c[5];
      k++;
    end
    v[k] = c[1]; k++;
    if (c[2]) begin v[k] = c[1]; k++; end
    n = k;
    return v;
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!bit_tick);
  endtask

  task automatic run_frame(input logic [7:0] d, input logic [6:0] c,
                           input bit scramble, input string tag);
    logic [11:0] exp_v, got_v;
    int n;
    bit busy_ok = 1'b1;
    @(negedge clk);
    set_cfg(c);
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    check(busy && !tx_ready, "R11 busy after accept", {busy, tx_ready}, 2'b10);
    if (scramble) set_cfg(7'($urandom));
    exp_v = expect_bits(d, c, n);
    got_v = '0;
    for (int i = 0; i < n; i++) begin
      wait_tick();
      @(negedge clk);
      got_v[i] = txd;
      if (!busy || tx_ready) busy_ok = 1'b0;
    end
    check(got_v == exp_v, tag, int'(got_v), int'(exp_v));
    check(busy_ok, "R11 busy through frame", busy_ok, 1);
    wait_tick();
    @(negedge clk);
    check(!busy && txd == ~cfg_start_lvl, "R7 rest after last stop",
          {busy, txd}, {1'b0, ~cfg_start_lvl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_data = '0; tx_valid = 1'b0; flush = 1'b0;
    cfg_flow_en = 1'b0; cts_n = 1'b0;
    set_cfg(7'b0000010);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && tx_ready && txd == 1'b1, "R1 reset state",
          {busy, tx_ready, txd}, 3'b011);

    cfg_start_lvl = 1'b1;
    @(negedge clk);
    check(txd == 1'b0, "R2 rest follows start level", txd, 0);
    cfg_start_lvl = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R2 rest follows start level", txd, 1);

    run_frame(8'hA5, 7'b0000010, 1'b0, "R3 R4 lsb first 8N1");
    run_frame(8'h3C, 7'b1000010, 1'b0, "R4 msb first");
    run_frame(8'h81, 7'b0101010, 1'b0, "R5 literal ninth bit one");
    run_frame(8'h81, 7'b0001010, 1'b0, "R5 literal ninth bit zero");
    run_frame(8'h07, 7'b0011010, 1'b0, "R6 even parity");
    run_frame(8'h07, 7'b0111010, 1'b0, "R6 odd parity");
    run_frame(8'hF0, 7'b0111010, 1'b0, "R6 odd parity even data");
    run_frame(8'h5A, 7'b0000110, 1'b0, "R7 two stop bits");
    run_frame(8'h96, 7'b0000001, 1'b0, "R7 high start low stop");
    run_frame(8'hC3, 7'b1111101, 1'b1, "R10 config changed mid frame");

    // R8: flow control blocks while synchronized CTS is high
    @(negedge clk);
    set_cfg(7'b0000010);
    cfg_flow_en = 1'b1; cts_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_ready, "R8 ready held low by CTS", tx_ready, 0);
    tx_data = 8'h11; tx_valid = 1'b1;
    repeat (20) @(negedge clk);
    check(!busy && txd == 1'b1, "R8 no frame while CTS high", {busy, txd}, 2'b01);
    tx_valid = 1'b0;
    cts_n = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_ready, "R8 ready after CTS asserted", tx_ready, 1);
    run_frame(8'h6E, 7'b0000010, 1'b0, "R8 frame with CTS asserted");
    cfg_flow_en = 1'b0; cts_n = 1'b1;
    repeat (4) @(negedge clk);
    check(tx_ready, "R8 CTS ignored with flow off", tx_ready, 1);
    run_frame(8'h29, 7'b0011010, 1'b0, "R8 frame ignores CTS");
    cts_n = 1'b0;

    // R9: flush partway through a frame
    @(negedge clk);
    set_cfg(7'b0000010);
    tx_data = 8'h00; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (3) wait_tick();
    @(negedge clk);
    check(busy && txd == 1'b0, "R9 mid frame data low", {busy, txd}, 2'b10);
    flush = 1'b1;
    #1;
    check(!tx_ready, "R9 ready low during flush", tx_ready, 0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    check(!busy && txd == 1'b1 && tx_ready, "R9 idle after flush",
          {busy, txd, tx_ready}, 3'b011);
    run_frame(8'hE7, 7'b0000010, 1'b0, "R9 frame after flush");

    for (int t = 0; t < 30; t++) begin
      logic [6:0] c = 7'($urandom);
      logic [7:0] d = 8'($urandom);
      run_frame(d, c, 1'b1, "R10 R4 R6 random frame");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule